// File: doc/BRIEF.md
# IR Carrier Waveform Generator

This block produces the square-wave carrier for an infrared transmitter. Each carrier period is a high phase followed by a low phase. The length of each phase is a programmable number of ticks of a modulation clock, and that clock is chosen from four sources. The carrier output goes to an envelope sequencer, which gates it on and off to form marks and spaces. A one-cycle strobe at the end of every period lets the sequencer count whole carrier periods.

All tick sources are enable pulses in the block's single clock domain:
- the system clock itself, which ticks every cycle;
- the crystal tick divided by three;
- an external 1 µs tick;
- an external 10 µs tick.

Software writes a control word and a phase-count word through a simple register port. A new count takes effect only at the next period boundary, so reprogramming never cuts a pulse short. An init-high control holds the output at the high level while the block is being set up. The reset values give 13 high and 13 low ticks of the 1 µs source, which is about a 38 kHz carrier at 50% duty.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, the control word reads 0x0000_2000 (disabled, init-high clear, 1 µs source) and the phase-count word reads 0x000C_000C. The carrier and the period-end strobe are low.
- R2: Writes and reads use two offsets. Offset 0x0 is control: bit 0 is enable, bit 2 is init-high, and bits 13:12 select the source; all other bits read as 0. Offset 0x4 holds the phase counts: bits 31:16 are the high count minus one and bits 15:0 are the low count minus one. A write to any other offset changes neither word.
- R3: With source 0 (system clock) and enable set, the output is high from the first cycle after the enabling write. It stays high for H cycles, then low for L cycles, and repeats with period H+L.
- R4: With source 1, one modulation tick is one in every three crystal tick pulses. The divider restarts whenever the block is disabled.
- R5: Source 2 counts 1 µs tick pulses and source 3 counts 10 µs tick pulses. The tick inputs that are not selected have no effect on the carrier.
- R6: While init-high is set, the output is high, whether the block is enabled or not.
- R7: While enable is clear, the output is low (unless init-high is set) and the counters are held reset. Re-enabling starts a full-length high phase.
- R8: A phase-count write made during a period does not change that period. The new counts apply from the next period on.
- R9: The period-end strobe is high for exactly one cycle: the cycle in which the output starts a new high phase after the last low tick of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | DATA_W | Register read data (combinational) |
| xtal_tick | input | 1 | Crystal-rate enable pulse |
| tick_1us | input | 1 | 1 µs enable pulse |
| tick_10us | input | 1 | 10 µs enable pulse |
| carrier_o | output | 1 | Carrier waveform |
| period_end_o | output | 1 | One-cycle strobe at each carrier period boundary |

## Verification
The bench reprograms the phase counts in the middle of a period. A design that loads new counts at once would produce a runt phase of the wrong length within that period. It disables the block mid-phase and then re-enables it. A design that does not clear its counters would resume partway through a phase instead of giving a full high phase. It drives the unused tick inputs at unrelated rates while one source is selected, and it runs the crystal path across a disable. A wrong mux or a divider that keeps its phase would put the carrier edges on the wrong ticks. Finally, it checks that init-high overrides an enabled carrier, and that the period strobe lands exactly on the rising edge that starts each period.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
   localparam int SRC_W        = 2;
   localparam int OFF_CTRL     = 'h0;
   localparam int OFF_MOD      = 'h4;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_INIT_BIT = 2;
   localparam int CTRL_SRC_LSB = 12;
   localparam int MOD_HI_LSB   = 16;
   localparam int MOD_LO_LSB   = 0;

   typedef enum logic [SRC_W-1:0] {
      SRC_SYS   = 2'd0,
      SRC_XTAL  = 2'd1,
      SRC_US1   = 2'd2,
      SRC_US10  = 2'd3
   } ircg_src_e;

   typedef enum logic {
      PH_HIGH = 1'b0,
      PH_LOW  = 1'b1
   } ircg_phase_e;
endpackage

// File: rtl/ircg_regs.sv
module ircg_regs
   import ircg_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int RST_SRC   = 2,
   parameter int RST_HI_M1 = 12,
   parameter int RST_LO_M1 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              en_o,
   output logic              init_high_o,
   output ircg_src_e         src_o,
   output logic [CNT_W-1:0]  hi_m1_o,
   output logic [CNT_W-1:0]  lo_m1_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(OFF_MOD);
   localparam ircg_src_e         SRC_RST = ircg_src_e'(SRC_W'(RST_SRC));

   if (DATA_W != 32) begin : g_chk_data
      $error("ircg_regs: DATA_W must be 32");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_chk_cnt
      $error("ircg_regs: CNT_W must lie in 1..16");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("ircg_regs: ADDR_W must reach offset 0x4");
   end

   logic              en_q;
   logic              init_q;
   ircg_src_e         src_q;
   logic [CNT_W-1:0]  hi_q;
   logic [CNT_W-1:0]  lo_q;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         init_q <= 1'b0;
         src_q  <= SRC_RST;
         hi_q   <= CNT_W'(RST_HI_M1);
         lo_q   <= CNT_W'(RST_LO_M1);
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            en_q   <= wr_data[CTRL_EN_BIT];
            init_q <= wr_data[CTRL_INIT_BIT];
            src_q  <= ircg_src_e'(wr_data[CTRL_SRC_LSB +: SRC_W]);
         end else if (wr_addr == A_MOD) begin
            hi_q <= wr_data[MOD_HI_LSB +: CNT_W];
            lo_q <= wr_data[MOD_LO_LSB +: CNT_W];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[CTRL_EN_BIT]               = en_q;
         rd_data[CTRL_INIT_BIT]             = init_q;
         rd_data[CTRL_SRC_LSB +: SRC_W]     = src_q;
      end else if (rd_addr == A_MOD) begin
         rd_data[MOD_HI_LSB +: CNT_W]       = hi_q;
         rd_data[MOD_LO_LSB +: CNT_W]       = lo_q;
      end
   end

   assign en_o        = en_q;
   assign init_high_o = init_q;
   assign src_o       = src_q;
   assign hi_m1_o     = hi_q;
   assign lo_m1_o     = lo_q;

   // R2: writes to an unmapped offset leave both words untouched
   assert_bad_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != A_CTRL && wr_addr != A_MOD) |=>
         ($stable(en_q) && $stable(init_q) && $stable(src_q) &&
          $stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/ircg_tick_sel.sv
module ircg_tick_sel
   import ircg_pkg::*;
#(
   parameter int XTAL_DIV = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  ircg_src_e src,
   input  logic      xtal_tick,
   input  logic      tick_1us,
   input  logic      tick_10us,
   output logic      tick_o
);
   if (XTAL_DIV < 1) begin : g_chk_div
      $error("ircg_tick_sel: XTAL_DIV must be at least 1");
   end

   logic xtal_div_tick;

   if (XTAL_DIV == 1) begin : g_div_bypass
      assign xtal_div_tick = xtal_tick;
   end else begin : g_div_count
      localparam int DIV_W = $clog2(XTAL_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(XTAL_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (!run) begin
            div_q <= '0;
         end else if (xtal_tick) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
         end
      end

      assign xtal_div_tick = xtal_tick && (div_q == DIV_LAST);
   end

   always_comb begin
      unique case (src)
         SRC_SYS:  tick_o = 1'b1;
         SRC_XTAL: tick_o = xtal_div_tick;
         SRC_US1:  tick_o = tick_1us;
         SRC_US10: tick_o = tick_10us;
         default:  tick_o = 1'b0;
      endcase
   end

   // R4: a divided crystal tick only ever coincides with a crystal pulse
   assert_xtal_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_XTAL && tick_o) |-> xtal_tick);
endmodule

// File: rtl/ircg_phase_ctr.sv
module ircg_phase_ctr
   import ircg_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int RST_HI_M1 = 12,
   parameter int RST_LO_M1 = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] hi_m1,
   input  logic [CNT_W-1:0] lo_m1,
   output logic             phase_high_o,
   output logic             period_end_o
);
   ircg_phase_e      phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hi_sh_q;
   logic [CNT_W-1:0] lo_sh_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_HIGH;
         cnt_q   <= '0;
         hi_sh_q <= CNT_W'(RST_HI_M1);
         lo_sh_q <= CNT_W'(RST_LO_M1);
         pend_q  <= 1'b0;
      end else if (!run) begin
         phase_q <= PH_HIGH;
         cnt_q   <= '0;
         hi_sh_q <= hi_m1;
         lo_sh_q <= lo_m1;
         pend_q  <= 1'b0;
      end else begin
         pend_q <= 1'b0;
         if (tick) begin
            if (phase_q == PH_HIGH) begin
               if (cnt_q == hi_sh_q) begin
                  phase_q <= PH_LOW;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               if (cnt_q == lo_sh_q) begin
                  phase_q <= PH_HIGH;
                  cnt_q   <= '0;
                  hi_sh_q <= hi_m1;
                  lo_sh_q <= lo_m1;
                  pend_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign phase_high_o = (phase_q == PH_HIGH);
   assign period_end_o = pend_q;

   // R7: a disabled cycle leaves the counter at the start of a high phase
   assert_held_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0 && phase_q == PH_HIGH && !pend_q));

   // R8: latched counts change only at a period boundary while running
   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !pend_q) |-> ($stable(hi_sh_q) && $stable(lo_sh_q)));

   // R9: the period strobe never lasts more than one cycle
   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !pend_q);

   // R3: the phase counter never passes the latched phase length
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ((phase_q == PH_HIGH) ? (cnt_q <= hi_sh_q) : (cnt_q <= lo_sh_q)));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
   import ircg_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int XTAL_DIV  = 3,
   parameter int RST_SRC   = 2,
   parameter int RST_HI_M1 = 12,
   parameter int RST_LO_M1 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              xtal_tick,
   input  logic              tick_1us,
   input  logic              tick_10us,
   output logic              carrier_o,
   output logic              period_end_o
);
   logic             en;
   logic             init_high;
   ircg_src_e        src;
   logic [CNT_W-1:0] hi_m1;
   logic [CNT_W-1:0] lo_m1;
   logic             tick;
   logic             phase_high;

   ircg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_SRC(RST_SRC),
      .RST_HI_M1(RST_HI_M1), .RST_LO_M1(RST_LO_M1)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .en_o(en), .init_high_o(init_high), .src_o(src),
      .hi_m1_o(hi_m1), .lo_m1_o(lo_m1)
   );

   ircg_tick_sel #(.XTAL_DIV(XTAL_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(en), .src(src),
      .xtal_tick(xtal_tick), .tick_1us(tick_1us), .tick_10us(tick_10us),
      .tick_o(tick)
   );

   ircg_phase_ctr #(
      .CNT_W(CNT_W), .RST_HI_M1(RST_HI_M1), .RST_LO_M1(RST_LO_M1)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .run(en), .tick(tick),
      .hi_m1(hi_m1), .lo_m1(lo_m1),
      .phase_high_o(phase_high), .period_end_o(period_end_o)
   );

   assign carrier_o = init_high | (en & phase_high);
endmodule

// File: tb/tb_ir_carrier_gen.sv
module tb_ir_carrier_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [31:0] wr_data;
   logic [3:0]  rd_addr;
   logic [31:0] rd_data;
   logic        xtal_tick, tick_1us, tick_10us;
   logic        carrier_o, period_end_o;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state, built from the requirements
   bit m_en, m_init, pe;
   int m_src, mH, mL, cH, cL, pos, xdiv, gcyc;

   always #4 clk = ~clk;

   ir_carrier_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .xtal_tick(xtal_tick), .tick_1us(tick_1us), .tick_10us(tick_10us),
      .carrier_o(carrier_o), .period_end_o(period_end_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, got, exp, gcyc);
      end
   endtask

   task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(tag, "rd_data", rd_data, exp);
   endtask

   // one clock cycle: check outputs, drive inputs, advance the model
   task automatic step(input string tag, input bit wr, input logic [3:0] a,
                       input logic [31:0] d);
      bit xt, t1, t10, tk;
      bit exp_c;
      exp_c = m_init | (m_en & (pos < cH));
      check(tag, "carrier", {31'b0, carrier_o}, {31'b0, exp_c});
      check("R9", "period_end", {31'b0, period_end_o}, {31'b0, pe});
      xt  = (gcyc % 2 == 0);
      t1  = (gcyc % 4 == 1);
      t10 = (gcyc % 9 == 3);
      xtal_tick = xt; tick_1us = t1; tick_10us = t10;
      wr_en = wr; wr_addr = a; wr_data = d;
      pe = 1'b0;
      tk = 1'b0;
      if (m_en) begin
         case (m_src)
            0: tk = 1'b1;
            1: begin
               tk = xt && (xdiv == 2);
               if (xt) xdiv = (xdiv == 2) ? 0 : xdiv + 1;
            end
            2: tk = t1;
            default: tk = t10;
         endcase
         if (tk) begin
            pos++;
            if (pos == cH + cL) begin
               pos = 0; cH = mH; cL = mL; pe = 1'b1;
            end
         end
      end else begin
         xdiv = 0;
      end
      if (wr) begin
         if (a == 4'h0) begin
            if (d[0] && !m_en) begin
               pos = 0; cH = mH; cL = mL;
            end
            m_en = d[0]; m_init = d[2]; m_src = int'(d[13:12]);
         end else if (a == 4'h4) begin
            mH = int'(d[31:16]) + 1;
            mL = int'(d[15:0]) + 1;
         end
      end
      gcyc++;
      @(negedge clk);
      wr_en = 1'b0; xtal_tick = 1'b0; tick_1us = 1'b0; tick_10us = 1'b0;
   endtask

   task automatic run(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1'b0, 4'h0, 32'h0);
   endtask

   task automatic t_reset;
      check("R1", "carrier", {31'b0, carrier_o}, 32'h0);
      check("R1", "period_end", {31'b0, period_end_o}, 32'h0);
      read_chk("R1", 4'h0, 32'h0000_2000);
      read_chk("R1", 4'h4, 32'h000C_000C);
      run("R1", 4);
   endtask

   task automatic t_regs;
      step("R2", 1'b1, 4'h0, 32'hFFFF_DFFA);
      read_chk("R2", 4'h0, 32'h0000_1000);
      step("R2", 1'b1, 4'h4, 32'h0003_0004);
      read_chk("R2", 4'h4, 32'h0003_0004);
      step("R2", 1'b1, 4'h8, 32'hFFFF_FFFF);
      step("R2", 1'b1, 4'hC, 32'hFFFF_FFFF);
      read_chk("R2", 4'h0, 32'h0000_1000);
      read_chk("R2", 4'h4, 32'h0003_0004);
      read_chk("R2", 4'h8, 32'h0);
      run("R2", 3);
   endtask

   task automatic t_sys;
      step("R3", 1'b1, 4'h4, 32'h0002_0001);
      step("R3", 1'b1, 4'h0, 32'h0000_0001);
      run("R3", 16);
      step("R3", 1'b1, 4'h0, 32'h0);
      run("R3", 2);
   endtask

   task automatic t_xtal;
      step("R4", 1'b1, 4'h4, 32'h0001_0002);
      step("R4", 1'b1, 4'h0, 32'h0000_1001);
      run("R4", 40);
      step("R4", 1'b1, 4'h0, 32'h0000_1000);
      run("R4", 3);
      step("R4", 1'b1, 4'h0, 32'h0000_1001);
      run("R4", 40);
      step("R4", 1'b1, 4'h0, 32'h0);
      run("R4", 2);
   endtask

   task automatic t_ticks;
      step("R5", 1'b1, 4'h4, 32'h0001_0001);
      step("R5", 1'b1, 4'h0, 32'h0000_2001);
      run("R5", 50);
      step("R5", 1'b1, 4'h0, 32'h0);
      step("R5", 1'b1, 4'h0, 32'h0000_3001);
      run("R5", 90);
      step("R5", 1'b1, 4'h0, 32'h0);
      run("R5", 2);
   endtask

   task automatic t_init;
      step("R6", 1'b1, 4'h4, 32'h0002_0001);
      step("R6", 1'b1, 4'h0, 32'h0000_0004);
      run("R6", 3);
      step("R6", 1'b1, 4'h0, 32'h0000_0005);
      run("R6", 12);
      step("R6", 1'b1, 4'h0, 32'h0000_0001);
      run("R6", 8);
      step("R6", 1'b1, 4'h0, 32'h0);
      run("R6", 2);
   endtask

   task automatic t_disable;
      step("R7", 1'b1, 4'h4, 32'h0002_0001);
      step("R7", 1'b1, 4'h0, 32'h0000_0001);
      run("R7", 4);
      step("R7", 1'b1, 4'h0, 32'h0);
      run("R7", 5);
      step("R7", 1'b1, 4'h0, 32'h0000_0001);
      run("R7", 7);
      step("R7", 1'b1, 4'h0, 32'h0);
      run("R7", 2);
   endtask

   task automatic t_update;
      step("R8", 1'b1, 4'h4, 32'h0003_0003);
      step("R8", 1'b1, 4'h0, 32'h0000_0001);
      run("R8", 3);
      step("R8", 1'b1, 4'h4, 32'h0001_0000);
      run("R8", 20);
      step("R8", 1'b1, 4'h4, 32'h0000_0002);
      run("R8", 12);
      step("R8", 1'b1, 4'h0, 32'h0);
      run("R8", 2);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      xtal_tick = 1'b0; tick_1us = 1'b0; tick_10us = 1'b0;
      m_en = 1'b0; m_init = 1'b0; pe = 1'b0; m_src = 2;
      mH = 13; mL = 13; cH = 13; cL = 13; pos = 0; xdiv = 0; gcyc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_sys();
      t_xtal();
      t_ticks();
      t_init();
      t_disable();
      t_update();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule